// File: doc/BRIEF.md
# I2C Register-Pair Slave for a Voltage Regulator Controller

This block is the serial control port of a step-down regulator. A system clock oversamples the two bus lines. Each line passes through a two-flop synchronizer and then a three-sample agreement filter before any edge is decoded. The block recognises START, repeated START and STOP. It answers a single 7-bit address and pulls SDA low through an output-enable, never driving it high. It has no SCL output, so it cannot stretch the clock.

A write frame carries any number of pointer/data byte pairs after the address. Each byte is acknowledged, and each data byte lands in its register only once its acknowledge clock has ended. A read sets the pointer in a write frame, then uses a repeated START with the read bit. The slave returns one byte, the master answers with NACK, and a STOP closes the frame.

The register file holds an identity code, a scratch byte, a ceiling for the voltage code, a status byte, a mode byte, a ramp-rate code and the target voltage code. The writable values are exported to the rest of the regulator control. The status byte mixes live condition inputs with event flags that stay set until they are read.

Top module: `pmic_i2c_regs`

## Requirements
- R1: The slave acknowledges only the 7-bit address {4'b0111, ADDR_MID, addr_sel}, which is 0x38 or 0x39 with the default ADDR_MID of 2'b00. Any other address gets no acknowledge, and the frame that follows is ignored.
- R2: An address byte of 0x00 (general call) is never acknowledged.
- R3: After an acknowledged write address, every pointer byte and every data byte is acknowledged. Pairs may repeat until STOP, and each pair writes the register its pointer names.
- R4: A read frame returns the register selected by the pointer from the preceding write. The form is address+W, pointer, repeated START, address+R. The byte is sent MSB first and followed by a master NACK.
- R5: A data byte changes a register only after its acknowledge clock has ended. A byte cut short by STOP changes nothing.
- R6: A STOP ends the frame at any point, except a STOP in the same SCL high phase as the START that began the frame. That STOP is ignored.
- R7: Register map:
  - 0x00 reads 0x03 and ignores writes.
  - 0x01 is an 8-bit scratch byte.
  - 0x02 holds a 7-bit ceiling.
  - 0x05 keeps only bits 7, 3, 2, 1 and 0.
  - 0x06 keeps bits 3:0.
  - 0x07 holds a 7-bit voltage code.
  - Bits that are not kept read as 0.
- R8: STATUS sits at 0x04. Bit 5 latches a thermal event and bit 2 latches an overcurrent event. Both stay set until STATUS is read and are cleared by that read. Bit 4 follows the undervoltage input and bit 3 the overvoltage input.
- R9: STATUS bit 1 is 1 whenever the voltage code (0x07) is greater than the ceiling (0x02). Bits 7, 6 and 0 are 0.
- R10: A pointer outside the map is acknowledged. A write through it is dropped, and a read through it returns 0x00.
- R11: After reset, the ceiling, mode, ramp and voltage outputs equal their reset parameters (mode masked as in R7), and SDA is released.
- R12: The output-enable on SDA changes only while the filtered SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| addr_sel | input | 1 | Selects address bit 0 |
| sda_oe | output | 1 | 1 pulls SDA low |
| thermal_evt | input | 1 | Pulse marking a thermal shutdown event |
| ocp_evt | input | 1 | Pulse marking an overcurrent event |
| uv_now | input | 1 | Output currently under target |
| ov_now | input | 1 | Output currently over target |
| vidmax_o | output | 7 | Voltage-code ceiling |
| cfg_o | output | 8 | Mode byte |
| slew_o | output | 4 | Ramp-rate code |
| vid_o | output | 7 | Target voltage code |

## Verification
Single-pair and multi-pair write frames show whether pointers and data stay paired across a long stream. Read frames over every mapped pointer, and over unmapped ones, separate the read mux from the write masks. Foreign, general-call and pin-selected addresses test the address decoder. Reading STATUS twice, around injected events and live inputs, separates sticky flags from live ones. A STOP in mid-byte and a STOP inside the START's own high phase test the framing corner cases. A reference model compares the exported registers on every clock.

// File: rtl/pmic_i2c_pkg.sv
package pmic_i2c_pkg;
    typedef enum logic [2:0] {
        ST_IDLE, ST_ADDR, ST_PTR, ST_DATA, ST_ACK, ST_TX, ST_MACK
    } bus_st_e;

    typedef enum logic [1:0] {AK_ADDR, AK_PTR, AK_DATA} ack_e;

    localparam logic [7:0] PTR_ID      = 8'h00;
    localparam logic [7:0] PTR_SCRATCH = 8'h01;
    localparam logic [7:0] PTR_VIDMAX  = 8'h02;
    localparam logic [7:0] PTR_STATUS  = 8'h04;
    localparam logic [7:0] PTR_CFG     = 8'h05;
    localparam logic [7:0] PTR_SLEW    = 8'h06;
    localparam logic [7:0] PTR_VID     = 8'h07;

    localparam logic [7:0] ID_CODE  = 8'h03;
    localparam logic [7:0] CFG_KEEP = 8'h8F;
endpackage

// File: rtl/i2c_glitch_filter.sv
module i2c_glitch_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int VOTE_LEN    = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic [VOTE_LEN-1:0]    hist;
        logic                   clean;
    } flt_s;

    flt_s q, d;

    always_comb begin
        d = q;
        d.sync = {q.sync[SYNC_STAGES-2:0], din};
        d.hist = {q.hist[VOTE_LEN-2:0], q.sync[SYNC_STAGES-1]};
        if (&q.hist)
            d.clean = 1'b1;
        else if (~|q.hist)
            d.clean = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '1;
        else        q <= d;
    end

    assign dout = q.clean;
endmodule

// File: rtl/i2c_pair_engine.sv
module i2c_pair_engine
    import pmic_i2c_pkg::*;
#(
    parameter logic [3:0] ADDR_HI  = 4'b0111,
    parameter logic [1:0] ADDR_MID = 2'b00
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl,
    input  logic       sda,
    input  logic       addr_sel,
    input  logic [7:0] rd_data,
    output logic       sda_oe,
    output logic [7:0] ptr,
    output logic       wr_en,
    output logic [7:0] wr_data,
    output logic       rd_strobe
);
    localparam logic [6:0] OWN_HI = {ADDR_HI, ADDR_MID};

    typedef struct packed {
        bus_st_e    st;
        ack_e       kind;
        logic [3:0] cnt;
        logic [7:0] sh;
        logic [7:0] ptr;
        logic       rw;
        logic       oe;
        logic       spulse;
        logic       scl_p;
        logic       sda_p;
        logic       we;
        logic       re;
    } eng_s;

    eng_s q, d;
    logic rise, fall, start, stop;

    always_comb begin
        rise  = scl & ~q.scl_p;
        fall  = ~scl & q.scl_p;
        start = scl & q.scl_p & q.sda_p & ~sda;
        stop  = scl & q.scl_p & ~q.sda_p & sda;

        d = q;
        d.scl_p = scl;
        d.sda_p = sda;
        d.we = 1'b0;
        d.re = 1'b0;
        if (fall) d.spulse = 1'b0;

        if (start) begin
            d.st = ST_ADDR;
            d.cnt = 4'd0;
            d.oe = 1'b0;
            d.spulse = 1'b1;
        end else if (stop && !q.spulse) begin
            d.st = ST_IDLE;
            d.oe = 1'b0;
        end else begin
            unique case (q.st)
                ST_ADDR, ST_PTR, ST_DATA: begin
                    if (rise) begin
                        d.sh = {q.sh[6:0], sda};
                        d.cnt = q.cnt + 4'd1;
                    end else if (fall && q.cnt == 4'd8) begin
                        d.cnt = 4'd0;
                        d.oe = 1'b1;
                        d.st = ST_ACK;
                        if (q.st == ST_ADDR) begin
                            d.kind = AK_ADDR;
                            d.rw = q.sh[0];
                            if (q.sh[7:1] != {OWN_HI, addr_sel} || q.sh == 8'h00) begin
                                d.oe = 1'b0;
                                d.st = ST_IDLE;
                            end
                        end else if (q.st == ST_PTR) begin
                            d.kind = AK_PTR;
                            d.ptr = q.sh;
                        end else begin
                            d.kind = AK_DATA;
                        end
                    end
                end
                ST_ACK: begin
                    if (fall) begin
                        d.oe = 1'b0;
                        unique case (q.kind)
                            AK_ADDR: begin
                                if (q.rw) begin
                                    d.st = ST_TX;
                                    d.sh = rd_data;
                                    d.oe = ~rd_data[7];
                                    d.cnt = 4'd1;
                                    d.re = 1'b1;
                                end else begin
                                    d.st = ST_PTR;
                                end
                            end
                            AK_PTR: d.st = ST_DATA;
                            default: begin
                                d.st = ST_PTR;
                                d.we = 1'b1;
                            end
                        endcase
                    end
                end
                ST_TX: begin
                    if (fall) begin
                        if (q.cnt == 4'd8) begin
                            d.oe = 1'b0;
                            d.st = ST_MACK;
                        end else begin
                            d.sh = {q.sh[6:0], 1'b0};
                            d.oe = ~q.sh[6];
                            d.cnt = q.cnt + 4'd1;
                        end
                    end
                end
                ST_MACK: if (rise) d.st = ST_IDLE;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
            q.st <= ST_IDLE;
            q.kind <= AK_ADDR;
            q.scl_p <= 1'b1;
            q.sda_p <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign sda_oe    = q.oe;
    assign ptr       = q.ptr;
    assign wr_en     = q.we;
    assign wr_data   = q.sh;
    assign rd_strobe = q.re;
endmodule

// File: rtl/pmic_reg_bank.sv
module pmic_reg_bank
    import pmic_i2c_pkg::*;
#(
    parameter logic [6:0] VIDMAX_RST = 7'h4E,
    parameter logic [7:0] CFG_RST    = 8'h08,
    parameter logic [3:0] SLEW_RST   = 4'h2,
    parameter logic [6:0] VID_RST    = 7'h2E
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] ptr,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       rd_strobe,
    input  logic       thermal_evt,
    input  logic       ocp_evt,
    input  logic       uv_now,
    input  logic       ov_now,
    output logic [7:0] rd_data,
    output logic [7:0] status_o,
    output logic [6:0] vidmax_o,
    output logic [7:0] cfg_o,
    output logic [3:0] slew_o,
    output logic [6:0] vid_o
);
    typedef struct packed {
        logic [7:0] scratch;
        logic [6:0] vidmax;
        logic [7:0] cfg;
        logic [3:0] slew;
        logic [6:0] vid;
        logic       hot;
        logic       oc;
    } rb_s;

    rb_s q, d;
    logic vmerr;

    always_comb begin
        d = q;
        if (wr_en) begin
            unique case (ptr)
                PTR_SCRATCH: d.scratch = wr_data;
                PTR_VIDMAX:  d.vidmax  = wr_data[6:0];
                PTR_CFG:     d.cfg     = wr_data & CFG_KEEP;
                PTR_SLEW:    d.slew    = wr_data[3:0];
                PTR_VID:     d.vid     = wr_data[6:0];
                default: ;
            endcase
        end
        if (rd_strobe && ptr == PTR_STATUS) begin
            d.hot = 1'b0;
            d.oc  = 1'b0;
        end
        if (thermal_evt) d.hot = 1'b1;
        if (ocp_evt)     d.oc  = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.scratch <= 8'h00;
            q.vidmax  <= VIDMAX_RST;
            q.cfg     <= CFG_RST & CFG_KEEP;
            q.slew    <= SLEW_RST;
            q.vid     <= VID_RST;
            q.hot     <= 1'b0;
            q.oc      <= 1'b0;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        vmerr = q.vid > q.vidmax;
        status_o = {2'b00, q.hot, uv_now, ov_now, q.oc, vmerr, 1'b0};
        unique case (ptr)
            PTR_ID:      rd_data = ID_CODE;
            PTR_SCRATCH: rd_data = q.scratch;
            PTR_VIDMAX:  rd_data = {1'b0, q.vidmax};
            PTR_STATUS:  rd_data = status_o;
            PTR_CFG:     rd_data = q.cfg;
            PTR_SLEW:    rd_data = {4'h0, q.slew};
            PTR_VID:     rd_data = {1'b0, q.vid};
            default:     rd_data = 8'h00;
        endcase
    end

    assign vidmax_o = q.vidmax;
    assign cfg_o    = q.cfg;
    assign slew_o   = q.slew;
    assign vid_o    = q.vid;
endmodule

// File: rtl/pmic_i2c_regs.sv
module pmic_i2c_regs #(
    parameter logic [1:0] ADDR_MID    = 2'b00,
    parameter int          SYNC_STAGES = 2,
    parameter int          VOTE_LEN    = 3,
    parameter logic [6:0]  VIDMAX_RST  = 7'h4E,
    parameter logic [7:0]  CFG_RST     = 8'h08,
    parameter logic [3:0]  SLEW_RST    = 4'h2,
    parameter logic [6:0]  VID_RST     = 7'h2E
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic       addr_sel,
    output logic       sda_oe,
    input  logic       thermal_evt,
    input  logic       ocp_evt,
    input  logic       uv_now,
    input  logic       ov_now,
    output logic [6:0] vidmax_o,
    output logic [7:0] cfg_o,
    output logic [3:0] slew_o,
    output logic [6:0] vid_o
);
    localparam int NLINES = 2;

    logic [NLINES-1:0] pad_raw, pad_clean;
    logic       scl_c, sda_c;
    logic [7:0] eng_ptr, eng_wdata, bank_rdata, stat_vec;
    logic       eng_we, eng_re;

    assign pad_raw = {scl_i, sda_i};

    for (genvar g = 0; g < NLINES; g++) begin : g_flt
        i2c_glitch_filter #(
            .SYNC_STAGES(SYNC_STAGES),
            .VOTE_LEN   (VOTE_LEN)
        ) u_flt (
            .clk (clk),
            .rst_n(rst_n),
            .din (pad_raw[g]),
            .dout(pad_clean[g])
        );
    end

    assign scl_c = pad_clean[1];
    assign sda_c = pad_clean[0];

    i2c_pair_engine #(
        .ADDR_MID(ADDR_MID)
    ) u_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl      (scl_c),
        .sda      (sda_c),
        .addr_sel (addr_sel),
        .rd_data  (bank_rdata),
        .sda_oe   (sda_oe),
        .ptr      (eng_ptr),
        .wr_en    (eng_we),
        .wr_data  (eng_wdata),
        .rd_strobe(eng_re)
    );

    pmic_reg_bank #(
        .VIDMAX_RST(VIDMAX_RST),
        .CFG_RST   (CFG_RST),
        .SLEW_RST  (SLEW_RST),
        .VID_RST   (VID_RST)
    ) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .ptr        (eng_ptr),
        .wr_en      (eng_we),
        .wr_data    (eng_wdata),
        .rd_strobe  (eng_re),
        .thermal_evt(thermal_evt),
        .ocp_evt    (ocp_evt),
        .uv_now     (uv_now),
        .ov_now     (ov_now),
        .rd_data    (bank_rdata),
        .status_o   (stat_vec),
        .vidmax_o   (vidmax_o),
        .cfg_o      (cfg_o),
        .slew_o     (slew_o),
        .vid_o      (vid_o)
    );
endmodule

// File: rtl/pmic_i2c_regs_chk.sv
module pmic_i2c_regs_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_c,
    input logic       sda_oe,
    input logic       wr_en,
    input logic       rd_strobe,
    input logic [7:0] ptr,
    input logic [6:0] vid_o,
    input logic       thermal_evt,
    input logic [7:0] stat_vec
);
    // R12: the data line is only moved while the clock is low
    a_r12_oe_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> !scl_c);

    // R5: the voltage code changes only after a commit strobe
    a_r5_vid_changes_on_commit: assert property (@(posedge clk) disable iff (!rst_n)
        (vid_o != $past(vid_o)) |-> $past(wr_en));

    // R8: a thermal event is latched on the next edge
    a_r8_vrhot_latches: assert property (@(posedge clk) disable iff (!rst_n)
        thermal_evt |=> stat_vec[5]);

    // R8: the overcurrent flag holds until a STATUS read
    a_r8_oc_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_vec[2] && !(rd_strobe && ptr == 8'h04)) |=> stat_vec[2]);

    // R3: a write commit and a read fetch never coincide
    a_r3_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_en, rd_strobe}));
endmodule

bind pmic_i2c_regs pmic_i2c_regs_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_c      (scl_c),
    .sda_oe     (sda_oe),
    .wr_en      (eng_we),
    .rd_strobe  (eng_re),
    .ptr        (eng_ptr),
    .vid_o      (vid_o),
    .thermal_evt(thermal_evt),
    .stat_vec   (stat_vec)
);

// File: tb/sim_pmic_i2c_regs.sv
`timescale 1ns/1ps
module sim_pmic_i2c_regs;
    localparam int Q = 12;
    localparam logic [6:0] R_VIDMAX = 7'h4E;
    localparam logic [7:0] R_CFG    = 8'h08;
    localparam logic [3:0] R_SLEW   = 4'h2;
    localparam logic [6:0] R_VID    = 7'h2E;

    logic clk = 1'b0, rst_n = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1, addr_sel = 1'b0;
    logic thermal_evt = 1'b0, ocp_evt = 1'b0, uv_now = 1'b0, ov_now = 1'b0;
    logic sda_oe, sda_i;
    logic [6:0] vidmax_o, vid_o;
    logic [7:0] cfg_o;
    logic [3:0] slew_o;

    int n_chk = 0, n_err = 0;
    bit cmp_en = 0, done = 0;

    logic [7:0] m_scratch = 8'h00;
    logic [6:0] m_vidmax = R_VIDMAX, m_vid = R_VID;
    logic [7:0] m_cfg = R_CFG & 8'h8F;
    logic [3:0] m_slew = R_SLEW;
    bit m_hot = 0, m_oc = 0;

    always #4 clk = ~clk;
    assign sda_i = sda_m & ~sda_oe;

    pmic_i2c_regs u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_i),
        .addr_sel(addr_sel), .sda_oe(sda_oe), .thermal_evt(thermal_evt),
        .ocp_evt(ocp_evt), .uv_now(uv_now), .ov_now(ov_now),
        .vidmax_o(vidmax_o), .cfg_o(cfg_o), .slew_o(slew_o), .vid_o(vid_o)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // R7 R11: exported registers compared with the model on every clock
    always @(negedge clk) begin
        if (cmp_en && rst_n) begin
            check({vidmax_o, cfg_o, slew_o, vid_o} == {m_vidmax, m_cfg, m_slew, m_vid},
                  "R7 per-clock regs", {vidmax_o, cfg_o, slew_o, vid_o},
                  {m_vidmax, m_cfg, m_slew, m_vid});
        end
    end

    function automatic logic [7:0] exp_read(input logic [7:0] p);
        case (p)
            8'h00: return 8'h03;
            8'h01: return m_scratch;
            8'h02: return {1'b0, m_vidmax};
            8'h04: return {2'b00, m_hot, uv_now, ov_now, m_oc, (m_vid > m_vidmax), 1'b0};
            8'h05: return m_cfg;
            8'h06: return {4'h0, m_slew};
            8'h07: return {1'b0, m_vid};
            default: return 8'h00;
        endcase
    endfunction

    function automatic void model_write(input logic [7:0] p, input logic [7:0] v);
        case (p)
            8'h01: m_scratch = v;
            8'h02: m_vidmax = v[6:0];
            8'h05: m_cfg = v & 8'h8F;
            8'h06: m_slew = v[3:0];
            8'h07: m_vid = v[6:0];
            default: ;
        endcase
    endfunction

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start;
        sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_stop;
        sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(2 * Q);
    endtask

    task automatic bit_out(input logic b);
        sda_m = b; tick(Q); scl_m = 1'b1; tick(2 * Q); scl_m = 1'b0; tick(Q);
    endtask

    task automatic bit_in(output logic b);
        sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
        b = sda_i; tick(Q); scl_m = 1'b0; tick(Q);
    endtask

    task automatic byte_out(input logic [7:0] v, output bit acked);
        logic a;
        for (int i = 7; i >= 0; i--) bit_out(v[i]);
        bit_in(a);
        acked = !a;
    endtask

    task automatic byte_in(output logic [7:0] v);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            bit_in(b);
            v[i] = b;
        end
        bit_out(1'b1);
    endtask

    task automatic send_addr(input logic [6:0] a, input logic rw, input bit exp_ack, input string tag);
        bit ak;
        byte_out({a, rw}, ak);
        check(ak == exp_ack, tag, ak, exp_ack);
    endtask

    task automatic send_pair(input logic [7:0] p, input logic [7:0] v, input string tag);
        bit ak;
        byte_out(p, ak);
        check(ak, {tag, " pointer ack"}, ak, 1);
        cmp_en = 0;
        byte_out(v, ak);
        check(ak, {tag, " data ack"}, ak, 1);
        model_write(p, v);
        cmp_en = 1;
    endtask

    task automatic read_reg(input logic [6:0] a, input logic [7:0] p, input string tag);
        logic [7:0] got, exp;
        bit ak;
        exp = exp_read(p);
        bus_start;
        send_addr(a, 1'b0, 1, {tag, " addr+W"});
        byte_out(p, ak);
        check(ak, {tag, " pointer ack"}, ak, 1);
        bus_start;
        send_addr(a, 1'b1, 1, {tag, " addr+R"});
        byte_in(got);
        bus_stop;
        check(got == exp, tag, got, exp);
        if (p == 8'h04) begin
            m_hot = 0;
            m_oc = 0;
        end
    endtask

    task automatic pulse(input bit which);
        if (which) thermal_evt = 1'b1; else ocp_evt = 1'b1;
        tick(1);
        thermal_evt = 1'b0;
        ocp_evt = 1'b0;
        if (which) m_hot = 1; else m_oc = 1;
        tick(2);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        logic [7:0] ptrs [4];
        logic [7:0] vals [4];
        ptrs = '{8'h05, 8'h06, 8'h02, 8'h01};
        vals = '{8'hFF, 8'hFF, 8'h50, 8'hA5};
        tick(5);
        rst_n = 1'b1;
        tick(20);
        // R11 reset state
        check({vidmax_o, cfg_o, slew_o, vid_o} == {R_VIDMAX, R_CFG & 8'h8F, R_SLEW, R_VID},
              "R11 reset values", {vidmax_o, cfg_o, slew_o, vid_o},
              {R_VIDMAX, R_CFG & 8'h8F, R_SLEW, R_VID});
        check(sda_oe == 1'b0, "R11 sda released", sda_oe, 0);
        cmp_en = 1;

        // R3 single pair
        bus_start;
        send_addr(7'h38, 1'b0, 1, "R1 own address");
        send_pair(8'h07, 8'h2A, "R3 single pair");
        bus_stop;

        // R3 several pairs in one frame, R7 masks
        bus_start;
        send_addr(7'h38, 1'b0, 1, "R3 multi addr");
        for (int i = 0; i < 4; i++) send_pair(ptrs[i], vals[i], "R3 multi pair");
        bus_stop;

        // R4 R7 reads over the map
        read_reg(7'h38, 8'h00, "R7 read ID");
        read_reg(7'h38, 8'h01, "R4 read scratch");
        read_reg(7'h38, 8'h02, "R4 read ceiling");
        read_reg(7'h38, 8'h05, "R7 read mode masked");
        read_reg(7'h38, 8'h06, "R7 read ramp masked");
        read_reg(7'h38, 8'h07, "R4 read voltage");

        // R10 unmapped pointers, R7 ID read-only
        bus_start;
        send_addr(7'h38, 1'b0, 1, "R10 addr");
        send_pair(8'h03, 8'h77, "R10 unmapped write");
        send_pair(8'h00, 8'hFF, "R7 ID write");
        bus_stop;
        read_reg(7'h38, 8'h03, "R10 unmapped read");
        read_reg(7'h38, 8'h2B, "R10 far unmapped read");
        read_reg(7'h38, 8'h00, "R7 ID unchanged");

        // R1 foreign address and R2 general call
        bus_start;
        send_addr(7'h3A, 1'b0, 0, "R1 foreign address nack");
        for (int i = 0; i < 8; i++) bit_out(1'b0);
        bus_stop;
        bus_start;
        send_addr(7'h00, 1'b0, 0, "R2 general call nack");
        bus_stop;

        // R1 pin-selected address bit
        addr_sel = 1'b1;
        tick(4);
        bus_start;
        send_addr(7'h39, 1'b0, 1, "R1 addr_sel=1 match");
        send_pair(8'h07, 8'h60, "R1 write via 0x39");
        bus_stop;
        bus_start;
        send_addr(7'h38, 1'b0, 0, "R1 0x38 nack when addr_sel=1");
        bus_stop;
        addr_sel = 1'b0;
        tick(4);

        // R8 R9 status flags
        uv_now = 1'b1;
        pulse(1'b1);
        pulse(1'b0);
        read_reg(7'h38, 8'h04, "R8 status sticky set");
        read_reg(7'h38, 8'h04, "R8 status cleared by read");
        uv_now = 1'b0;
        ov_now = 1'b1;
        bus_start;
        send_addr(7'h38, 1'b0, 1, "R9 addr");
        send_pair(8'h07, 8'h10, "R9 voltage below ceiling");
        bus_stop;
        read_reg(7'h38, 8'h04, "R9 vmerr clear, ov live");
        ov_now = 1'b0;

        // R5 STOP inside a data byte discards it
        bus_start;
        send_addr(7'h38, 1'b0, 1, "R5 addr");
        begin
            bit ak;
            byte_out(8'h07, ak);
            check(ak, "R5 pointer ack", ak, 1);
        end
        for (int i = 0; i < 4; i++) bit_out(1'b1);
        bus_stop;
        read_reg(7'h38, 8'h07, "R5 partial byte dropped");

        // R6 STOP in the START's own high phase is ignored
        sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b0; tick(Q);
        send_addr(7'h38, 1'b0, 1, "R6 frame survives early STOP");
        send_pair(8'h07, 8'h33, "R6 write after early STOP");
        bus_stop;
        read_reg(7'h38, 8'h07, "R6 read back");

        tick(20);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule